// File: doc/BRIEF.md
# Threshold-Signalling Data Buffer

This block is a 32-word, 16-bit circular buffer. It sits between the host register side and a card-side transfer engine. Words enter through a push stream and leave through a pop stream. The surrounding logic wires the host and the card engine to these two streams according to the transfer direction. Every clock cycle the block compares its fill level with two programmable thresholds and raises a pacing indication for the outside world.

In the receive direction, a fill level above the almost-full threshold means the host should drain words. In the transmit direction, a fill level below the almost-empty threshold means the host should supply words. Each indication goes to one of two places, chosen by the enable bit for that direction in the threshold register:
- a DMA request line, when the enable bit is set;
- a polled level flag, when the enable bit is clear.

Back-pressure follows these rules:
- `in_ready` is low while the buffer holds 32 words. A word offered then is dropped and is not stored.
- `out_valid` is low while the buffer is empty. Asserting `out_ready` then has no effect.
- `out_data` always shows the word at the read position, even when the buffer is empty.

Top module: `thr_dbuf`

## Requirements
- R1: Words leave in the order they entered. Storage is 32 entries of 16 bits, and both positions wrap from 31 back to 0.
- R2: A push is accepted only while `fill_level` is below 32. `in_ready` is low at 32, and a word offered then is discarded and never appears at `out_data`.
- R3: A pop request while empty leaves `fill_level` and the read position unchanged. `out_valid` is low, and `out_data` shows the word stored at the current read position.
- R4: A push and a pop accepted in the same cycle both take effect, and `fill_level` keeps its value.
- R5: Threshold register layout, as written and as read back on `cfg_rdata`:
  - bit 15 is the receive DMA enable;
  - bits 12:8 are the almost-full level;
  - bit 7 is the transmit DMA enable;
  - bits 4:0 are the almost-empty level;
  - bits 14:13 and 6:5 are written as zero and read as zero.
- R6: With `dir_rx`=1 and `fill_level` greater than the almost-full level, `rx_dma_req` is 1 if the receive DMA enable is set. Otherwise `rx_lvl_flag` is 1. When the condition is false, both are 0.
- R7: With `dir_rx`=0 and `fill_level` less than the almost-empty level, `tx_dma_req` is 1 if the transmit DMA enable is set. Otherwise `tx_lvl_flag` is 1. When the condition is false, both are 0.
- R8: While `xfer_active` is 0 and the buffer is empty, both level flags are cleared and both DMA requests keep their previous values.
- R9: After reset:
  - `fill_level` is 0 and every request and flag is 0;
  - the almost-full level is 31 and the almost-empty level is 0, so `cfg_rdata` reads 16'h1F00;
  - with `dir_rx`=1, 31 stored words raise nothing.
- R10: The clock edge that loads a threshold-register write with a DMA enable set also clears that direction's level flag.
- R11: Requests and flags are registered. They reflect the level and register contents one clock edge after those change.
- R12: `fill_level` is 6 bits wide and reports the full value 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Push stream: word offered |
| in_data | input | 16 | Push stream: word |
| in_ready | output | 1 | Push stream: space available |
| out_valid | output | 1 | Pop stream: word available |
| out_data | output | 16 | Pop stream: word at read position |
| out_ready | input | 1 | Pop stream: consumer takes word |
| dir_rx | input | 1 | 1 = receive direction, 0 = transmit direction |
| xfer_active | input | 1 | A block transfer is in progress |
| cfg_we | input | 1 | Write strobe for the threshold register |
| cfg_wdata | input | 16 | Threshold register write value |
| cfg_rdata | output | 16 | Threshold register contents |
| fill_level | output | 6 | Words stored |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_lvl_flag | output | 1 | Receive level flag, for polled operation |
| tx_lvl_flag | output | 1 | Transmit level flag, for polled operation |

## Verification
Two cases are of most interest. In the first, a push and a pop arrive in the same cycle. Stimulus vectors interleave both-side operations over a model queue, and each one is judged by an unchanged `fill_level` and by the order of the words that come out. In the second, a push is offered to a full buffer while a pop is taken in the same cycle. The push must still be refused, because readiness is decided from the level before the edge, so the level drops to 31 and the refused word must never appear in the drained sequence. A third collision is also checked: a threshold-register write that arrives in the same cycle as a level-flag update. That case is judged by the flag being clear right after the write edge, and by the DMA request appearing one edge later.

// File: rtl/thr_dbuf_pkg.sv
package thr_dbuf_pkg;
  localparam int DATA_W_DEF = 16;
  localparam int DEPTH_DEF  = 32;
  localparam int THR_W      = 5;
  localparam int CFG_W      = 16;
  // Register field positions (software-visible layout)
  localparam int RXEN_BIT   = 15;
  localparam int AF_LSB     = 8;
  localparam int TXEN_BIT   = 7;
  localparam int AE_LSB     = 0;

  typedef struct packed {
    logic             rx_en;
    logic [THR_W-1:0] af_lvl;
    logic             tx_en;
    logic [THR_W-1:0] ae_lvl;
  } thr_cfg_t;

  function automatic thr_cfg_t cfg_decode(input logic [CFG_W-1:0] w);
    thr_cfg_t c;
    c.rx_en  = w[RXEN_BIT];
    c.af_lvl = w[AF_LSB +: THR_W];
    c.tx_en  = w[TXEN_BIT];
    c.ae_lvl = w[AE_LSB +: THR_W];
    return c;
  endfunction

  function automatic logic [CFG_W-1:0] cfg_encode(input thr_cfg_t c);
    logic [CFG_W-1:0] w;
    w = '0;
    w[RXEN_BIT]         = c.rx_en;
    w[AF_LSB +: THR_W]  = c.af_lvl;
    w[TXEN_BIT]         = c.tx_en;
    w[AE_LSB +: THR_W]  = c.ae_lvl;
    return w;
  endfunction
endpackage

// File: rtl/thr_dbuf_store.sv
module thr_dbuf_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  level,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
    end
  end

  assign rdata = mem[rd_ptr];

  // R1: pointer distance (mod DEPTH) agrees with the separately kept level
  a_r1_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(wr_ptr) + DEPTH - int'(rd_ptr)) % DEPTH) == (int'(level) % DEPTH))
    else $error("a_r1_ptr_gap");
endmodule

// File: rtl/thr_dbuf_level.sv
module thr_dbuf_level #(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) level <= '0;
    else if (push && !pop) level <= level + 1'b1;
    else if (pop && !push) level <= level - 1'b1;
  end

  assign full  = (level == CNT_W'(DEPTH));
  assign empty = (level == '0);

  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CNT_W'(DEPTH)) else $error("a_r2_no_overflow");

  a_r2_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full) else $error("a_r2_full_hold");

  a_r3_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && !push |=> level == '0) else $error("a_r3_empty_pop");

  a_r4_both_stable: assert property (@(posedge clk) disable iff (!rst_n)
    push && pop |=> $stable(level)) else $error("a_r4_both_stable");
endmodule

// File: rtl/thr_dbuf_thresh.sv
module thr_dbuf_thresh
  import thr_dbuf_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             dir_rx,
  input  logic             xfer_active,
  input  logic [CNT_W-1:0] level,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             rx_req,
  output logic             tx_req,
  output logic             rx_flag,
  output logic             tx_flag
);
  localparam thr_cfg_t CFG_RST = '{rx_en: 1'b0, af_lvl: THR_W'(DEPTH-1),
                                   tx_en: 1'b0, ae_lvl: '0};

  thr_cfg_t cfg_q, cfg_new;
  logic     rx_hit, tx_hit, idle_empty;

  assign cfg_new = cfg_decode(cfg_wdata);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_new;
  end

  assign cfg_rdata  = cfg_encode(cfg_q);
  assign rx_hit     = dir_rx  && (level > CNT_W'(cfg_q.af_lvl));
  assign tx_hit     = !dir_rx && (level < CNT_W'(cfg_q.ae_lvl));
  assign idle_empty = !xfer_active && (level == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_req  <= 1'b0;
      tx_req  <= 1'b0;
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else begin
      if (idle_empty) begin
        rx_flag <= 1'b0;
        tx_flag <= 1'b0;
      end else begin
        rx_req  <= rx_hit && cfg_q.rx_en;
        rx_flag <= rx_hit && !cfg_q.rx_en;
        tx_req  <= tx_hit && cfg_q.tx_en;
        tx_flag <= tx_hit && !cfg_q.tx_en;
      end
      if (cfg_we && cfg_new.rx_en) rx_flag <= 1'b0;
      if (cfg_we && cfg_new.tx_en) tx_flag <= 1'b0;
    end
  end

  a_r5_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (cfg_wdata[14:13] == 2'b00 && cfg_wdata[6:5] == 2'b00))
    else $error("a_r5_resv_zero");

  a_r6_rx_dir: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |-> $past(dir_rx)) else $error("a_r6_rx_dir");

  a_r7_tx_dir: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flag |-> !$past(dir_rx)) else $error("a_r7_tx_dir");

  a_r8_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    idle_empty |=> !rx_flag && !tx_flag) else $error("a_r8_idle_clear");

  a_r8_dma_hold: assert property (@(posedge clk) disable iff (!rst_n)
    idle_empty |=> $stable(rx_req) && $stable(tx_req)) else $error("a_r8_dma_hold");

  a_r10_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[RXEN_BIT] |=> !rx_flag) else $error("a_r10_rx_clear");

  a_r10_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[TXEN_BIT] |=> !tx_flag) else $error("a_r10_tx_clear");
endmodule

// File: rtl/thr_dbuf.sv
module thr_dbuf
  import thr_dbuf_pkg::*;
#(
  parameter int DATA_W = DATA_W_DEF,
  parameter int DEPTH  = DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  input  logic              dir_rx,
  input  logic              xfer_active,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  output logic [CNT_W-1:0]  fill_level,
  output logic              rx_dma_req,
  output logic              tx_dma_req,
  output logic              rx_lvl_flag,
  output logic              tx_lvl_flag
);
  logic push_fire, pop_fire, full, empty;

  assign in_ready  = !full;
  assign out_valid = !empty;
  assign push_fire = in_valid && in_ready;
  assign pop_fire  = out_ready && out_valid;

  thr_dbuf_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .push(push_fire), .pop(pop_fire),
    .level(fill_level), .full(full), .empty(empty)
  );

  thr_dbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_fire), .pop(pop_fire),
    .wdata(in_data), .level(fill_level), .rdata(out_data)
  );

  thr_dbuf_thresh #(.DEPTH(DEPTH)) u_thresh (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .dir_rx(dir_rx), .xfer_active(xfer_active), .level(fill_level),
    .cfg_rdata(cfg_rdata), .rx_req(rx_dma_req), .tx_req(tx_dma_req),
    .rx_flag(rx_lvl_flag), .tx_flag(tx_lvl_flag)
  );
endmodule

// File: tb/thr_dbuf_tb.sv
`timescale 1ns/1ps
module thr_dbuf_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready, out_valid;
  logic [15:0] out_data;
  logic        out_ready = 1'b0;
  logic        dir_rx = 1'b0;
  logic        xfer_active = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [5:0]  fill_level;
  logic        rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag;

  int n_tests = 0;
  int n_fail  = 0;
  logic [15:0] q [$];

  always #4 clk = ~clk;

  thr_dbuf u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .dir_rx(dir_rx), .xfer_active(xfer_active),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .fill_level(fill_level), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .rx_lvl_flag(rx_lvl_flag), .tx_lvl_flag(tx_lvl_flag)
  );

  // {push, pop, data, expected level after the edge}
  localparam logic [23:0] VEC [10] = '{
    {1'b1, 1'b0, 16'hA001, 6'd1},
    {1'b1, 1'b0, 16'hA002, 6'd2},
    {1'b1, 1'b1, 16'hA003, 6'd2},
    {1'b0, 1'b1, 16'h0000, 6'd1},
    {1'b1, 1'b1, 16'hA004, 6'd1},
    {1'b0, 1'b1, 16'h0000, 6'd0},
    {1'b0, 1'b1, 16'h0000, 6'd0},
    {1'b1, 1'b0, 16'hA005, 6'd1},
    {1'b1, 1'b1, 16'hA006, 6'd1},
    {1'b0, 1'b1, 16'h0000, 6'd0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic step(input logic p, input logic [15:0] d, input logic r);
    in_valid  = p;
    in_data   = d;
    out_ready = r;
    cyc();
    in_valid  = 1'b0;
    out_ready = 1'b0;
  endtask

  task automatic wcfg(input logic [15:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    cyc();
    cfg_we    = 1'b0;
    cfg_wdata = '0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    // R9 reset state
    chk("R9", "level", fill_level, 0);
    chk("R9", "in_ready", in_ready, 1);
    chk("R9", "out_valid", out_valid, 0);
    chk("R9", "req/flags", {rx_dma_req, tx_dma_req, rx_lvl_flag, tx_lvl_flag}, 0);
    chk("R9", "cfg reset value", cfg_rdata, 16'h1F00);

    // R1/R4 vector walk with model queue
    for (int i = 0; i < 10; i++) begin
      automatic logic [23:0] v = VEC[i];
      automatic int sz = q.size();
      if (v[22] && sz > 0) chk("R1", "pop data", out_data, q[0]);
      step(v[23], v[21:6], v[22]);
      if (v[22] && sz > 0) void'(q.pop_front());
      if (v[23] && sz < 32) q.push_back(v[21:6]);
      chk("R4", "level after vector", fill_level, v[5:0]);
    end

    // R2/R9/R6/R12: fill in receive direction with reset thresholds
    dir_rx = 1'b1;
    xfer_active = 1'b1;
    for (int i = 0; i < 31; i++) begin
      step(1'b1, 16'h5000 + 16'(i), 1'b0);
      q.push_back(16'h5000 + 16'(i));
    end
    cyc();
    cyc();
    chk("R9", "level 31 no rx flag", {rx_lvl_flag, rx_dma_req}, 0);
    step(1'b1, 16'h501F, 1'b0);
    q.push_back(16'h501F);
    chk("R12", "level full", fill_level, 32);
    chk("R2", "in_ready at full", in_ready, 0);
    chk("R11", "rx flag not yet", rx_lvl_flag, 0);
    cyc();
    chk("R6", "rx flag polled", rx_lvl_flag, 1);
    chk("R6", "rx dma idle", rx_dma_req, 0);
    chk("R4", "front before both", out_data, q[0]);
    step(1'b1, 16'hDEAD, 1'b1);
    void'(q.pop_front());
    chk("R2", "push refused while full", fill_level, 31);
    while (q.size() > 0) begin
      chk("R1", "drain order across wrap", out_data, q[0]);
      step(1'b0, 16'h0, 1'b1);
      void'(q.pop_front());
    end
    chk("R1", "drained", fill_level, 0);

    // R3 empty read
    chk("R3", "out_valid empty", out_valid, 0);
    chk("R3", "word at read position", out_data, 16'h5000);
    step(1'b0, 16'h0, 1'b1);
    chk("R3", "level after empty pop", fill_level, 0);
    chk("R3", "data after empty pop", out_data, 16'h5000);
    step(1'b1, 16'h7777, 1'b0);
    chk("R3", "read position unmoved", out_data, 16'h7777);
    step(1'b0, 16'h0, 1'b1);

    // R7/R8/R10/R11 transmit thresholds
    dir_rx = 1'b0;
    wcfg(16'h1F04);
    chk("R5", "readback", cfg_rdata, 16'h1F04);
    chk("R11", "tx flag one edge late", tx_lvl_flag, 0);
    cyc();
    chk("R7", "tx flag polled", tx_lvl_flag, 1);
    chk("R7", "tx dma idle", tx_dma_req, 0);
    xfer_active = 1'b0;
    cyc();
    chk("R8", "idle empty clears flag", tx_lvl_flag, 0);
    xfer_active = 1'b1;
    cyc();
    cyc();
    chk("R7", "flag back", tx_lvl_flag, 1);
    wcfg(16'h1F84);
    chk("R10", "tx flag cleared on write edge", tx_lvl_flag, 0);
    cyc();
    chk("R7", "tx dma request", tx_dma_req, 1);
    xfer_active = 1'b0;
    cyc();
    cyc();
    chk("R8", "dma held idle", tx_dma_req, 1);
    chk("R8", "flag clear idle", tx_lvl_flag, 0);
    xfer_active = 1'b1;
    for (int i = 0; i < 4; i++) step(1'b1, 16'hC000 + 16'(i), 1'b0);
    cyc();
    chk("R7", "dma drops at level 4", tx_dma_req, 0);

    // R6/R10 receive thresholds
    dir_rx = 1'b1;
    wcfg(16'h8200);
    cyc();
    chk("R6", "rx dma request", rx_dma_req, 1);
    chk("R6", "rx flag with dma", rx_lvl_flag, 0);
    chk("R7", "tx silent in rx dir", {tx_dma_req, tx_lvl_flag}, 0);
    wcfg(16'h0200);
    cyc();
    chk("R6", "rx polled flag", rx_lvl_flag, 1);
    chk("R6", "rx dma off", rx_dma_req, 0);
    wcfg(16'h8200);
    chk("R10", "rx flag cleared on write edge", rx_lvl_flag, 0);
    chk("R5", "readback rx", cfg_rdata, 16'h8200);

    finish_run();
  end
endmodule